// File: doc/BRIEF.md
# Popcount Argmax Class Selector

This block sits at the end of a weightless, lookup-table based classifier. It takes the flat vector of single-bit lookup-table results and divides it into equal contiguous groups, one group for each class. It counts the set bits of each group with a tree of adders, and it registers those counts. A pairwise comparison tree then picks the class with the largest count, and a second register stage holds the winning index together with its count.

A valid flag travels beside the data. A new input vector is accepted on every clock edge where `in_valid` is high. The matching result appears two cycles later, and the pipeline never stalls. The class count, the group size and whether the score is presented at all are parameters. Count and index widths are derived from them.

Top module: `class_selector`

## Requirements
- R1: The score of class c is the number of ones in input bits [c*GROUP_BITS +: GROUP_BITS], so class 0 owns the least significant group.
- R2: `out_class` is the index of a class whose score is not below any other class's score, and `out_score` is that score.
- R3: When several classes share the top score, the lowest such index is reported.
- R4: `out_valid` is high in exactly the cycles that come two cycles after a cycle in which `in_valid` was sampled high. The result of that input is shown in the same cycle.
- R5: Inputs presented on consecutive cycles each produce their own result on consecutive cycles, with no gaps.
- R6: While no new result arrives, `out_class` and `out_score` keep their last values. Input bits presented with `in_valid` low do not change them.
- R7: A synchronous active-high `rst` clears `out_valid`, `out_class` and `out_score` to 0 on the next edge, and it also drops any result still in flight.
- R8: With `EMIT_SCORE` set to 0, `out_score` stays 0 and `out_class` is the same as with the score enabled.
- R9: Each count is $clog2(GROUP_BITS+1) bits wide, so a group whose bits are all ones reports exactly GROUP_BITS with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks `in_bits` as a vector to classify |
| in_bits | input | NUM_CLASSES*GROUP_BITS | Lookup-table result bits, grouped by class |
| out_valid | output | 1 | Result present this cycle |
| out_class | output | $clog2(NUM_CLASSES) (min 1) | Winning class index |
| out_score | output | $clog2(GROUP_BITS+1) | Winning count, or 0 when the score is disabled |

## Verification
The bench builds two instances with five classes of eight bits each. The first has the score enabled and the second has it disabled, so both variants of the output stage run on the same stimulus. Five classes is not a power of two, so the comparison tree becomes unbalanced and the odd class is paired at a different depth. Eight-bit groups let a single byte fill one class, which makes ties and a full count of 8 in a 4-bit field easy to set up directly.

// File: rtl/cls_sel_pkg.sv
package cls_sel_pkg;

    // Width needed to hold a count from 0 up to n inclusive.
    function automatic int count_width(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

    // Width needed to name one of n classes (never below 1).
    function automatic int index_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    // Default configuration: five classes.
    localparam int DEF_CLASSES    = 5;
    localparam int DEF_GROUP_BITS = 8;

endpackage

// File: rtl/csel_popcount_tree.sv
// Recursive adder tree: splits the bit vector in halves and sums the halves.
module csel_popcount_tree #(
    parameter  int N  = 8,
    localparam int OW = cls_sel_pkg::count_width(N)
) (
    input  logic [N-1:0]  bits_i,
    output logic [OW-1:0] count_o
);
    generate
        if (N == 1) begin : g_leaf
            assign count_o = bits_i;
        end else begin : g_split
            localparam int NL = N / 2;
            localparam int NH = N - NL;
            localparam int WL = cls_sel_pkg::count_width(NL);
            localparam int WH = cls_sel_pkg::count_width(NH);
            logic [WL-1:0] cnt_lo;
            logic [WH-1:0] cnt_hi;

            csel_popcount_tree #(.N(NL)) u_lo (
                .bits_i  (bits_i[NL-1:0]),
                .count_o (cnt_lo)
            );
            csel_popcount_tree #(.N(NH)) u_hi (
                .bits_i  (bits_i[N-1:NL]),
                .count_o (cnt_hi)
            );

            assign count_o = OW'(cnt_lo) + OW'(cnt_hi);
        end
    endgenerate
endmodule

// File: rtl/csel_count_stage.sv
// Stage 1: per-class popcount followed by a register stage.
module csel_count_stage #(
    parameter  int NUM_CLASSES = 5,
    parameter  int GROUP_BITS  = 8,
    localparam int CW          = cls_sel_pkg::count_width(GROUP_BITS),
    localparam int TOTAL_BITS  = NUM_CLASSES * GROUP_BITS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [TOTAL_BITS-1:0]     in_bits,
    output logic                      cnt_valid,
    output logic [NUM_CLASSES*CW-1:0] cnt_vec
);
    logic [CW-1:0] cnt_next [NUM_CLASSES];
    logic [CW-1:0] cnt_q    [NUM_CLASSES];
    logic          valid_q;

    genvar c;
    generate
        for (c = 0; c < NUM_CLASSES; c++) begin : g_class
            csel_popcount_tree #(.N(GROUP_BITS)) u_tree (
                .bits_i  (in_bits[c*GROUP_BITS +: GROUP_BITS]),
                .count_o (cnt_next[c])
            );

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt_q[c] <= '0;
                end else if (in_valid) begin
                    cnt_q[c] <= cnt_next[c];
                end
            end

            assign cnt_vec[c*CW +: CW] = cnt_q[c];

            AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
                valid_q |-> (int'(cnt_q[c]) <= GROUP_BITS)); // R9
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= in_valid;
        end
    end

    assign cnt_valid = valid_q;

    AST_STAGE1_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> cnt_valid); // R4
    AST_STAGE1_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !cnt_valid); // R4
endmodule

// File: rtl/csel_argmax_node.sv
// Recursive pairwise comparison tree; the lower-index side wins ties.
module csel_argmax_node #(
    parameter int N    = 5,
    parameter int BASE = 0,
    parameter int IW   = 3,
    parameter int CW   = 4
) (
    input  logic [N*CW-1:0] scores_i,
    output logic [IW-1:0]   idx_o,
    output logic [CW-1:0]   score_o
);
    generate
        if (N == 1) begin : g_leaf
            localparam logic [IW-1:0] MY_IDX = IW'(BASE);
            assign idx_o   = MY_IDX;
            assign score_o = scores_i;
        end else begin : g_pair
            localparam int NL = N / 2;
            localparam int NH = N - NL;
            logic [IW-1:0] idx_lo,   idx_hi;
            logic [CW-1:0] score_lo, score_hi;
            logic          take_hi;

            csel_argmax_node #(.N(NL), .BASE(BASE), .IW(IW), .CW(CW)) u_lo (
                .scores_i (scores_i[NL*CW-1:0]),
                .idx_o    (idx_lo),
                .score_o  (score_lo)
            );
            csel_argmax_node #(.N(NH), .BASE(BASE + NL), .IW(IW), .CW(CW)) u_hi (
                .scores_i (scores_i[N*CW-1:NL*CW]),
                .idx_o    (idx_hi),
                .score_o  (score_hi)
            );

            // Strict compare: equal scores keep the lower-index side.
            assign take_hi = score_hi > score_lo;
            assign idx_o   = take_hi ? idx_hi   : idx_lo;
            assign score_o = take_hi ? score_hi : score_lo;
        end
    endgenerate
endmodule

// File: rtl/csel_pick_stage.sv
// Stage 2: argmax over registered counts followed by the output register.
module csel_pick_stage #(
    parameter  int NUM_CLASSES = 5,
    parameter  int GROUP_BITS  = 8,
    parameter  bit EMIT_SCORE  = 1'b1,
    localparam int CW          = cls_sel_pkg::count_width(GROUP_BITS),
    localparam int IW          = cls_sel_pkg::index_width(NUM_CLASSES)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cnt_valid,
    input  logic [NUM_CLASSES*CW-1:0] cnt_vec,
    output logic                      out_valid,
    output logic [IW-1:0]             out_class,
    output logic [CW-1:0]             out_score
);
    typedef struct packed {
        logic [IW-1:0] idx;
        logic [CW-1:0] score;
    } pick_t;

    pick_t pick_comb;
    pick_t pick_q;
    logic  valid_q;

    csel_argmax_node #(.N(NUM_CLASSES), .BASE(0), .IW(IW), .CW(CW)) u_tree (
        .scores_i (cnt_vec),
        .idx_o    (pick_comb.idx),
        .score_o  (pick_comb.score)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            pick_q  <= '0;
        end else begin
            valid_q <= cnt_valid;
            if (cnt_valid) begin
                pick_q <= pick_comb;
            end
        end
    end

    assign out_valid = valid_q;
    assign out_class = pick_q.idx;

    generate
        if (EMIT_SCORE) begin : g_score
            assign out_score = pick_q.score;
        end else begin : g_no_score
            assign out_score = '0;
        end
    endgenerate

    // Checks comparing the chosen result with every registered count.
    genvar i;
    generate
        for (i = 0; i < NUM_CLASSES; i++) begin : g_chk
            logic [CW-1:0] cnt_i;
            assign cnt_i = cnt_vec[i*CW +: CW];

            AST_WINNER_NOT_BELOW: assert property (@(posedge clk) disable iff (rst)
                cnt_valid |=> ($past(cnt_i) <= pick_q.score)); // R2
            AST_TIE_LOWEST: assert property (@(posedge clk) disable iff (rst)
                cnt_valid |=> ((int'(pick_q.idx) <= i) || ($past(cnt_i) < pick_q.score))); // R3
        end
    endgenerate

    AST_CLASS_RANGE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int'(out_class) < NUM_CLASSES)); // R2
    AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        cnt_valid |=> out_valid); // R4
    AST_OUT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !cnt_valid |=> !out_valid); // R4
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
        !cnt_valid |=> ($stable(out_class) && $stable(out_score))); // R6
    AST_SCORE_OFF: assert property (@(posedge clk) disable iff (rst)
        !EMIT_SCORE |-> (out_score == '0)); // R8
endmodule

// File: rtl/class_selector.sv
module class_selector #(
    parameter  int NUM_CLASSES = cls_sel_pkg::DEF_CLASSES,
    parameter  int GROUP_BITS  = cls_sel_pkg::DEF_GROUP_BITS,
    parameter  bit EMIT_SCORE  = 1'b1,
    localparam int CW          = cls_sel_pkg::count_width(GROUP_BITS),
    localparam int IW          = cls_sel_pkg::index_width(NUM_CLASSES),
    localparam int TOTAL_BITS  = NUM_CLASSES * GROUP_BITS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [TOTAL_BITS-1:0] in_bits,
    output logic                  out_valid,
    output logic [IW-1:0]         out_class,
    output logic [CW-1:0]         out_score
);
    logic                      cnt_valid;
    logic [NUM_CLASSES*CW-1:0] cnt_vec;

    csel_count_stage #(
        .NUM_CLASSES (NUM_CLASSES),
        .GROUP_BITS  (GROUP_BITS)
    ) u_count (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_bits   (in_bits),
        .cnt_valid (cnt_valid),
        .cnt_vec   (cnt_vec)
    );

    csel_pick_stage #(
        .NUM_CLASSES (NUM_CLASSES),
        .GROUP_BITS  (GROUP_BITS),
        .EMIT_SCORE  (EMIT_SCORE)
    ) u_pick (
        .clk       (clk),
        .rst       (rst),
        .cnt_valid (cnt_valid),
        .cnt_vec   (cnt_vec),
        .out_valid (out_valid),
        .out_class (out_class),
        .out_score (out_score)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!out_valid && out_class == '0 && out_score == '0)); // R7
endmodule

// File: tb/class_selector_test.sv
module class_selector_test;
    localparam int NC = 5;
    localparam int GB = 8;
    localparam int TB = NC * GB;
    localparam int NV = 8;
    localparam int NR = 200;

    // Table: input vector, expected class, expected score.
    localparam logic [TB-1:0] VEC [NV] = '{
        40'h00_00_00_00_00,   // all zero: tie at 0 -> class 0
        40'hFF_FF_FF_FF_FF,   // all full: tie at 8 -> class 0
        40'h00_FF_00_00_00,   // class 3 full
        40'h01_03_07_0F_1F,   // descending: class 0 with 5
        40'h1F_0F_07_03_01,   // ascending: class 4 with 5
        40'h00_0F_00_F0_03,   // tie 1 and 3 at 4 -> class 1
        40'h80_00_00_00_00,   // single bit in class 4
        40'hFF_7F_FF_00_00    // tie 2 and 4 at 8 -> class 2
    };
    localparam int EXP_CLS [NV] = '{0, 0, 3, 0, 4, 1, 4, 2};
    localparam int EXP_SC  [NV] = '{0, 8, 8, 5, 5, 4, 1, 8};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [TB-1:0] in_bits = '0;
    logic          out_valid, ns_valid;
    logic [2:0]    out_class, ns_class;
    logic [3:0]    out_score, ns_score;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    class_selector #(.NUM_CLASSES(NC), .GROUP_BITS(GB), .EMIT_SCORE(1'b1)) uut (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_bits (in_bits),
        .out_valid (out_valid), .out_class (out_class), .out_score (out_score)
    );

    class_selector #(.NUM_CLASSES(NC), .GROUP_BITS(GB), .EMIT_SCORE(1'b0)) uut_ns (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_bits (in_bits),
        .out_valid (ns_valid), .out_class (ns_class), .out_score (ns_score)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Independent reference: count each group, keep first maximum.
    task automatic ref_eval(input logic [TB-1:0] v, output int cls, output int sc);
        cls = 0;
        sc  = -1;
        for (int c = 0; c < NC; c++) begin
            int n = 0;
            for (int b = 0; b < GB; b++) n += int'(v[c*GB + b]);
            if (n > sc) begin
                sc  = n;
                cls = c;
            end
        end
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200_000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        logic [TB-1:0] rvec [NR];
        int rcls [NR];
        int rsc  [NR];
        int hold_cls, hold_sc;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7 reset out_valid", int'(out_valid), 0);
        chk("R7 reset out_class", int'(out_class), 0);
        chk("R7 reset out_score", int'(out_score), 0);
        rst = 1'b0;

        // Table walk, streamed back to back (R1 R2 R3 R5 R8 R9).
        for (int k = 0; k < NV + 2; k++) begin
            @(negedge clk);
            if (k >= 2) begin
                chk("R4 R5 table out_valid", int'(out_valid), 1);
                chk("R1 R2 R3 table class", int'(out_class), EXP_CLS[k-2]);
                chk("R1 R9 table score", int'(out_score), EXP_SC[k-2]);
                chk("R8 no-score class", int'(ns_class), EXP_CLS[k-2]);
                chk("R8 no-score score", int'(ns_score), 0);
            end
            if (k < NV) begin
                in_valid = 1'b1;
                in_bits  = VEC[k];
            end else begin
                in_valid = 1'b0;
            end
        end

        // Random stream; every other vector thinned to provoke ties.
        for (int k = 0; k < NR; k++) begin
            logic [TB-1:0] v;
            v = {$urandom, $urandom};
            if (k % 2 == 1) v = v & TB'({$urandom, $urandom}) & TB'({$urandom, $urandom});
            rvec[k] = v;
            ref_eval(v, rcls[k], rsc[k]);
        end
        for (int k = 0; k < NR + 2; k++) begin
            @(negedge clk);
            if (k >= 2) begin
                chk("R4 R5 random out_valid", int'(out_valid), 1);
                chk("R2 R3 random class", int'(out_class), rcls[k-2]);
                chk("R1 random score", int'(out_score), rsc[k-2]);
            end
            if (k < NR) begin
                in_valid = 1'b1;
                in_bits  = rvec[k];
            end else begin
                in_valid = 1'b0;
            end
        end

        // Latency of a lone input (R4).
        @(negedge clk);
        chk("R4 idle before pulse", int'(out_valid), 0);
        in_valid = 1'b1;
        in_bits  = VEC[2];
        @(negedge clk);
        in_valid = 1'b0;
        chk("R4 one cycle after", int'(out_valid), 0);
        @(negedge clk);
        chk("R4 two cycles after", int'(out_valid), 1);
        chk("R4 pulse class", int'(out_class), 3);
        @(negedge clk);
        chk("R4 three cycles after", int'(out_valid), 0);

        // Hold with invalid inputs (R6).
        hold_cls = int'(out_class);
        hold_sc  = int'(out_score);
        in_bits  = '1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R6 hold class", int'(out_class), hold_cls);
            chk("R6 hold score", int'(out_score), hold_sc);
            chk("R6 hold out_valid", int'(out_valid), 0);
        end

        // Reset with a result in flight (R7).
        in_valid = 1'b1;
        in_bits  = VEC[4];
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        chk("R7 flush out_valid", int'(out_valid), 0);
        chk("R7 flush class", int'(out_class), 0);
        chk("R7 flush score", int'(out_score), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R7 no late result", int'(out_valid), 0);

        done = 1'b1;
        finish_run();
    end
endmodule